// File: doc/BRIEF.md
# Lane Deskew Character Buffer

This block serves one receive lane of a multi-lane serial converter link and runs at character rate: one decoded character enters on every clock. A character carries a control flag, a disparity-error flag, a not-in-table error flag and eight data bits. While the link is in its initial lane alignment phase, the block waits for the first alignment marker, a control character with data 0x7C. From that character onward it writes every incoming character into a circular store and sends out only the idle comma (K28.5). Ready tells the cross-lane logic that this lane has found its marker.

When the shared start strobe arrives in the data phase, the block replays the store from the marker onward, one character per clock. The write side keeps running, so the lane's latency stays fixed from then on. Because every lane begins its replay on the same strobe, all lanes leave the block deskewed to a common point. Frame size F and multiframe size K are configuration inputs set at run time. Their product is the most characters a lane may hold while waiting. If the store grows past that, the lane reports a sticky error.

The character stream has no valid/ready handshake and no back-pressure. The lane delivers one character on every clock and the block takes it unconditionally. Downstream logic must accept one output character per clock.

Top module: `lane_aligner`

## Requirements
- R1: While rst_n is low (active low), and on the first clock after reset, ready, aligned and error are 0 and the output character is the filler.
- R2: Whenever aligned is 0, the output character is the filler K28.5: control flag 1, data 0xBC, both error flags 0.
- R3: Ready rises one clock after a character with control flag 1 and data 0x7C is taken while link_state is ILAS (2'd2). A 0x7C with the control flag clear, or a control 0x7C in any other state, does not arm the block.
- R4: Start taken while ready is 1 and link_state is DATA (2'd3) raises aligned one clock later. The output then carries the stored characters in arrival order, starting with the 0x7C marker, one per clock.
- R5: Start is ignored while link_state is not DATA, and it is ignored before ready.
- R6: Once aligned, each output character equals the input character from N clocks earlier, where N is the number of characters stored when start was taken. N stays fixed during replay.
- R7: With link state encoding INIT=0, CGS=1, ILAS=2, DATA=3: if ready is high and more than F×K characters (capped at DEPTH) would be stored without start, error rises, ready drops, and error holds until reset. The block cannot re-arm while error is set.
- R8: When link_state is INIT or CGS, ready and aligned clear on the next clock, the output returns to the filler, and a later marker re-arms the block.
- R9: The disparity-error and not-in-table flags of stored characters are replayed unchanged.
- R10: Error stays 0 during normal arming and replay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_octets | input | 9 | F, octets per frame (1..256) |
| cfg_frames | input | 6 | K, frames per multiframe (1..32) |
| link_state | input | 2 | 0 INIT, 1 CGS, 2 ILAS, 3 DATA |
| start | input | 1 | Common replay start strobe |
| in_k | input | 1 | Input control flag |
| in_disp_err | input | 1 | Input disparity error flag |
| in_nit_err | input | 1 | Input not-in-table error flag |
| in_data | input | 8 | Input data octet |
| out_k | output | 1 | Output control flag |
| out_disp_err | output | 1 | Output disparity error flag |
| out_nit_err | output | 1 | Output not-in-table error flag |
| out_data | output | 8 | Output data octet |
| ready | output | 1 | Marker found, lane storing |
| aligned | output | 1 | Replay running |
| error | output | 1 | Sticky overflow error |

## Verification
Four things are checked by assertions on every clock:
- the filler is present whenever aligned is low;
- aligned never appears without ready;
- error is sticky and excludes ready;
- the write-to-read pointer gap does not move during replay.

Arming on a marker is also checked on every clock. Some behaviour can only be shown by the bench scenarios:
- the replayed content and its order;
- the exact latency;
- that the error flags pass through storage unchanged;
- the overflow threshold for a given F×K;
- that start is ignored outside the data state or before arming.

// File: rtl/lane_align_pkg.sv
package lane_align_pkg;

  typedef enum logic [1:0] {
    LS_INIT = 2'd0,
    LS_CGS  = 2'd1,
    LS_ILAS = 2'd2,
    LS_DATA = 2'd3
  } link_state_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ARMED  = 2'd1,
    ST_REPLAY = 2'd2,
    ST_FAULT  = 2'd3
  } align_state_e;

  typedef struct packed {
    logic       k;
    logic       disp_err;
    logic       nit_err;
    logic [7:0] data;
  } lane_char_t;

  localparam logic [7:0] MARKER_OCTET = 8'h7C;
  localparam logic [7:0] COMMA_OCTET  = 8'hBC;
  localparam lane_char_t FILLER_CHAR  = '{k: 1'b1, disp_err: 1'b0, nit_err: 1'b0, data: 8'hBC};

endpackage

// File: rtl/la_limit.sv
module la_limit #(
  parameter int OCT_W = 9,
  parameter int FRM_W = 6,
  parameter int DEPTH = 256,
  localparam int CW   = $clog2(DEPTH) + 1,
  localparam int PW   = OCT_W + FRM_W
) (
  input  logic [OCT_W-1:0] cfg_octets,
  input  logic [FRM_W-1:0] cfg_frames,
  output logic [CW-1:0]    limit
);
  logic [PW-1:0] product;

  always_comb begin
    product = PW'(cfg_octets) * PW'(cfg_frames);
    if (product > PW'(DEPTH)) limit = CW'(DEPTH);
    else                      limit = CW'(product);
  end
endmodule

// File: rtl/la_store.sv
module la_store
  import lane_align_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wr_addr,
  input  lane_char_t    wr_char,
  input  logic [AW-1:0] rd_addr,
  output lane_char_t    rd_char
);
  lane_char_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wr_addr] <= wr_char;
  end

  assign rd_char = mem[rd_addr];
endmodule

// File: rtl/la_ctrl.sv
module la_ctrl
  import lane_align_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    link_state,
  input  logic          start,
  input  logic          marker_seen,
  input  logic [CW-1:0] limit,
  output logic          we,
  output logic          rd_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic          ready,
  output logic          aligned,
  output logic          error
);
  align_state_e state_q, state_d;
  logic [AW-1:0] wr_ptr, rd_ptr, gap;
  logic [CW-1:0] fill;
  logic link_reset, arm, go, overflow;

  always_comb begin
    link_reset = (link_state == LS_INIT) || (link_state == LS_CGS);
    arm        = (state_q == ST_IDLE) && (link_state == LS_ILAS) && marker_seen;
    go         = (state_q == ST_ARMED) && start && (link_state == LS_DATA);
    overflow   = (state_q == ST_ARMED) && !go && !link_reset && (fill >= limit);
    we         = arm
               || ((state_q == ST_ARMED) && !overflow && !link_reset)
               || ((state_q == ST_REPLAY) && !link_reset);
    rd_en      = go || ((state_q == ST_REPLAY) && !link_reset);
  end

  always_comb begin
    state_d = state_q;
    if (state_q != ST_FAULT && link_reset) state_d = ST_IDLE;
    else begin
      case (state_q)
        ST_IDLE:   if (arm) state_d = ST_ARMED;
        ST_ARMED:  if (go) state_d = ST_REPLAY;
                   else if (overflow) state_d = ST_FAULT;
        default:   state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      fill    <= '0;
    end else begin
      state_q <= state_d;
      if (link_reset || overflow) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
        fill   <= '0;
      end else begin
        if (we)    wr_ptr <= wr_ptr + 1'b1;
        if (rd_en) rd_ptr <= rd_ptr + 1'b1;
        if (arm)   fill   <= CW'(1);
        else if ((state_q == ST_ARMED) && we && !go) fill <= fill + 1'b1;
      end
    end
  end

  assign wr_addr = wr_ptr;
  assign rd_addr = rd_ptr;
  assign gap     = wr_ptr - rd_ptr;
  assign ready   = (state_q == ST_ARMED) || (state_q == ST_REPLAY);
  assign aligned = (state_q == ST_REPLAY);
  assign error   = (state_q == ST_FAULT);

  // R4: replay never runs without the lane being armed
  assert_aligned_needs_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    aligned |-> ready);

  // R7: error is sticky until reset
  assert_error_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> error);

  // R7: a faulted lane never reports ready
  assert_fault_not_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> !ready);

  // R6: pointer gap frozen during replay, so latency is fixed
  assert_gap_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (aligned && !link_reset) |=> $stable(gap));

  // R7: storage never exceeds its depth
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH));
endmodule

// File: rtl/lane_aligner.sv
module lane_aligner
  import lane_align_pkg::*;
#(
  parameter int OCT_W = 9,
  parameter int FRM_W = 6,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OCT_W-1:0] cfg_octets,
  input  logic [FRM_W-1:0] cfg_frames,
  input  logic [1:0]       link_state,
  input  logic             start,
  input  logic             in_k,
  input  logic             in_disp_err,
  input  logic             in_nit_err,
  input  logic [7:0]       in_data,
  output logic             out_k,
  output logic             out_disp_err,
  output logic             out_nit_err,
  output logic [7:0]       out_data,
  output logic             ready,
  output logic             aligned,
  output logic             error
);
  lane_char_t in_char, rd_char, out_q;
  logic [CW-1:0] limit;
  logic [AW-1:0] wr_addr, rd_addr;
  logic we, rd_en, marker_seen;

  assign in_char     = '{k: in_k, disp_err: in_disp_err, nit_err: in_nit_err, data: in_data};
  assign marker_seen = in_k && (in_data == MARKER_OCTET);

  la_limit #(.OCT_W(OCT_W), .FRM_W(FRM_W), .DEPTH(DEPTH)) u_limit (
    .cfg_octets (cfg_octets),
    .cfg_frames (cfg_frames),
    .limit      (limit)
  );

  la_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .link_state  (link_state),
    .start       (start),
    .marker_seen (marker_seen),
    .limit       (limit),
    .we          (we),
    .rd_en       (rd_en),
    .wr_addr     (wr_addr),
    .rd_addr     (rd_addr),
    .ready       (ready),
    .aligned     (aligned),
    .error       (error)
  );

  la_store #(.DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .we      (we),
    .wr_addr (wr_addr),
    .wr_char (in_char),
    .rd_addr (rd_addr),
    .rd_char (rd_char)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= FILLER_CHAR;
    else        out_q <= rd_en ? rd_char : FILLER_CHAR;
  end

  assign out_k        = out_q.k;
  assign out_disp_err = out_q.disp_err;
  assign out_nit_err  = out_q.nit_err;
  assign out_data     = out_q.data;

  // R2: filler whenever replay is not running
  assert_filler_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !aligned |-> (out_k && !out_disp_err && !out_nit_err && out_data == COMMA_OCTET));

  // R3: marker in ILAS arms an idle lane
  assert_marker_arms_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !error && link_state == LS_ILAS && marker_seen) |=> ready);
endmodule

// File: tb/sim_lane_aligner.sv
module sim_lane_aligner;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] cfg_octets = 9'd2;
  logic [5:0] cfg_frames = 6'd2;
  logic [1:0] link_state = 2'd0;
  logic       start = 1'b0;
  logic       in_k = 1'b0, in_disp_err = 1'b0, in_nit_err = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       out_k, out_disp_err, out_nit_err, ready, aligned, error;
  logic [7:0] out_data;

  int checks = 0;
  int errors = 0;

  localparam logic [1:0] INIT = 2'd0, CGS = 2'd1, ILAS = 2'd2, DATA = 2'd3;

  always #5 clk = ~clk;

  lane_aligner u0 (
    .clk(clk), .rst_n(rst_n), .cfg_octets(cfg_octets), .cfg_frames(cfg_frames),
    .link_state(link_state), .start(start), .in_k(in_k), .in_disp_err(in_disp_err),
    .in_nit_err(in_nit_err), .in_data(in_data), .out_k(out_k), .out_disp_err(out_disp_err),
    .out_nit_err(out_nit_err), .out_data(out_data), .ready(ready), .aligned(aligned),
    .error(error)
  );

  typedef struct packed {
    logic [1:0] ls;
    logic       st;
    logic       k;
    logic       de;
    logic [7:0] d;
    logic       ek;
    logic       ede;
    logic [7:0] ed;
    logic       er;
    logic       ea;
    logic       ee;
  } row_t;

  localparam int NROWS = 15;
  localparam row_t TBL [NROWS] = '{
    '{INIT, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 8'hBC, 1'b0, 1'b0, 1'b0}, // R2
    '{CGS,  1'b0, 1'b1, 1'b0, 8'hBC, 1'b1, 1'b0, 8'hBC, 1'b0, 1'b0, 1'b0}, // R2
    '{CGS,  1'b0, 1'b1, 1'b0, 8'h7C, 1'b1, 1'b0, 8'hBC, 1'b0, 1'b0, 1'b0}, // R3 wrong state
    '{ILAS, 1'b0, 1'b0, 1'b0, 8'h7C, 1'b1, 1'b0, 8'hBC, 1'b0, 1'b0, 1'b0}, // R3 no k
    '{ILAS, 1'b0, 1'b1, 1'b0, 8'h7C, 1'b1, 1'b0, 8'hBC, 1'b1, 1'b0, 1'b0}, // R3 arm
    '{ILAS, 1'b0, 1'b0, 1'b0, 8'h01, 1'b1, 1'b0, 8'hBC, 1'b1, 1'b0, 1'b0}, // R2
    '{ILAS, 1'b0, 1'b0, 1'b1, 8'h02, 1'b1, 1'b0, 8'hBC, 1'b1, 1'b0, 1'b0}, // R9 flagged
    '{ILAS, 1'b1, 1'b0, 1'b0, 8'h03, 1'b1, 1'b0, 8'hBC, 1'b1, 1'b0, 1'b0}, // R5 start ignored
    '{DATA, 1'b1, 1'b0, 1'b0, 8'h04, 1'b1, 1'b0, 8'h7C, 1'b1, 1'b1, 1'b0}, // R4 marker first
    '{DATA, 1'b1, 1'b0, 1'b0, 8'h05, 1'b0, 1'b0, 8'h01, 1'b1, 1'b1, 1'b0}, // R4
    '{DATA, 1'b0, 1'b0, 1'b0, 8'h06, 1'b0, 1'b1, 8'h02, 1'b1, 1'b1, 1'b0}, // R9 flag kept
    '{DATA, 1'b0, 1'b0, 1'b0, 8'h07, 1'b0, 1'b0, 8'h03, 1'b1, 1'b1, 1'b0}, // R4
    '{DATA, 1'b0, 1'b0, 1'b0, 8'h08, 1'b0, 1'b0, 8'h04, 1'b1, 1'b1, 1'b0}, // R6
    '{DATA, 1'b0, 1'b0, 1'b0, 8'h09, 1'b0, 1'b0, 8'h05, 1'b1, 1'b1, 1'b0}, // R6 R10
    '{DATA, 1'b0, 1'b0, 1'b0, 8'h0A, 1'b0, 1'b0, 8'h06, 1'b1, 1'b1, 1'b0}  // R6 R10
  };

  task automatic chk(input string req, input logic [13:0] got, input logic [13:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got k/de/ne/data/rdy/al/err=%h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [13:0] outs();
    return {out_k, out_disp_err, out_nit_err, out_data, ready, aligned, error};
  endfunction

  task automatic cycle(input logic [1:0] ls, input logic st, input logic k,
                       input logic de, input logic [7:0] d);
    @(negedge clk);
    link_state = ls; start = st; in_k = k; in_disp_err = de; in_nit_err = 1'b0; in_data = d;
    @(posedge clk);
    #1;
  endtask

  localparam logic [13:0] FILL_IDLE = {1'b1, 1'b0, 1'b0, 8'hBC, 1'b0, 1'b0, 1'b0};
  localparam logic [13:0] FILL_RDY  = {1'b1, 1'b0, 1'b0, 8'hBC, 1'b1, 1'b0, 1'b0};
  localparam logic [13:0] FILL_ERR  = {1'b1, 1'b0, 1'b0, 8'hBC, 1'b0, 1'b0, 1'b1};

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 during reset", outs(), FILL_IDLE);
    @(negedge clk);
    rst_n = 1'b1;
    cycle(INIT, 1'b0, 1'b0, 1'b0, 8'h00);
    chk("R1 after reset", outs(), FILL_IDLE);

    for (int i = 0; i < NROWS; i++) begin
      cycle(TBL[i].ls, TBL[i].st, TBL[i].k, TBL[i].de, TBL[i].d);
      chk($sformatf("table row %0d", i), outs(),
          {TBL[i].ek, TBL[i].ede, 1'b0, TBL[i].ed, TBL[i].er, TBL[i].ea, TBL[i].ee});
    end

    // R8: fall back to CGS during replay
    cycle(CGS, 1'b0, 1'b1, 1'b0, 8'hBC);
    chk("R8 drop on CGS", outs(), FILL_IDLE);
    // R5: start before arming ignored
    cycle(DATA, 1'b1, 1'b0, 1'b0, 8'h11);
    chk("R5 start before ready", outs(), FILL_IDLE);

    // R7: overflow with F*K = 4
    cycle(ILAS, 1'b0, 1'b1, 1'b0, 8'h7C);
    chk("R8 re-arm", outs(), FILL_RDY);
    for (int i = 1; i < 4; i++) cycle(ILAS, 1'b0, 1'b0, 1'b0, 8'(i));
    chk("R7 full but ok", outs(), FILL_RDY);
    cycle(ILAS, 1'b0, 1'b0, 1'b0, 8'h20);
    chk("R7 overflow error", outs(), FILL_ERR);
    cycle(CGS, 1'b0, 1'b1, 1'b0, 8'hBC);
    cycle(ILAS, 1'b0, 1'b1, 1'b0, 8'h7C);
    chk("R7 sticky no re-arm", outs(), FILL_ERR);
    cycle(DATA, 1'b1, 1'b0, 1'b0, 8'h21);
    chk("R7 sticky in DATA", outs(), FILL_ERR);

    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    #1;
    chk("R1 reset clears error", outs(), FILL_IDLE);
    @(negedge clk);
    rst_n = 1'b1;

    // R6: F*K = 6, replay latency 6
    cfg_octets = 9'd3;
    cfg_frames = 6'd2;
    for (int i = 0; i < 18; i++) begin
      if (i == 0)      cycle(ILAS, 1'b0, 1'b1, 1'b0, 8'h7C);
      else if (i < 6)  cycle(ILAS, 1'b0, 1'b0, 1'b0, 8'(i));
      else             cycle(DATA, (i == 6), 1'b0, 1'b0, 8'(i));
      if (i < 6)       chk("R6 storing", outs(), FILL_RDY);
      else if (i == 6) chk("R4 marker out", outs(), {1'b1, 1'b0, 1'b0, 8'h7C, 1'b1, 1'b1, 1'b0});
      else             chk("R6 fixed latency", outs(), {1'b0, 1'b0, 1'b0, 8'(i - 6), 1'b1, 1'b1, 1'b0});
    end
    cycle(INIT, 1'b0, 1'b0, 1'b0, 8'h00);
    chk("R8 drop on INIT", outs(), FILL_IDLE);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule